// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block owns every refresh-related cycle of an EDO dynamic RAM. After reset it holds the memory idle through a long power-up pause. It then wakes the array with a burst of CAS-before-RAS (CBR) cycles and only after that reports the memory usable. In normal operation a free-running timer marks one refresh slot per interval. Each slot adds one owed refresh. The block asks the access controller for the pins with a request line and runs one CBR for every owed refresh while the grant is held. The device keeps its own row counter, so no address is produced.

A sleep request, honoured while the bus is granted and nothing is owed, puts the memory into self refresh. The block drops both column strobes and then the row strobe, and keeps them low. A wake request ends self refresh, but never before the minimum hold has elapsed. The exit always ends with a long precharge and exactly one CBR cycle. All phase lengths are parameters counted in clock cycles. The pause parameter can be made small for simulation.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, rasN, ucasN, lcasN and weN are high, busReq is low and ready is low.
- R2: For the first PWRUP_CYC clock edges after reset release all strobes stay high and busReq stays low. busReq rises on the next cycle.
- R3: After the pause, exactly INIT_CBR CBR cycles are issued whether or not busGrant is high. ready rises at the end of the last one's precharge and then never falls.
- R4: Every CBR cycle holds ucasN and lcasN low for T_CSR_CYC cycles with rasN high. It then holds all three low for T_RAS_CYC cycles, raises them together, and keeps all of them high for T_RP_CYC cycles. rasN is never low while a column strobe is high.
- R5: weN is high in every cycle.
- R6: Once ready is high, the timer adds one owed refresh every REF_CYC cycles, counted from reset release. Ticks before ready and ticks during self refresh are dropped. At most MAX_OWED refreshes are owed, and further ticks are lost.
- R7: A refresh starts only from idle with busGrant high. busReq is high whenever a refresh is owed, whenever sleepReq is high in idle after ready, and throughout any sequence. No strobe moves while busReq is low.
- R8: Owed refreshes run back to back, one idle cycle apart, so rasN stays high T_RP_CYC+1+T_CSR_CYC cycles between them.
- R9: With busGrant high, nothing owed and sleepReq high, self refresh starts. The column strobes fall, rasN falls T_CSR_CYC cycles later, and rasN then stays low for at least SELF_MIN_CYC cycles and until wakeReq is seen. Entry discards owed refreshes.
- R10: On self-refresh exit rasN stays high T_RPS_CYC+T_CSR_CYC cycles. This covers the exit precharge and the setup of exactly one CBR, which follows without a new grant check. The block then returns to idle with nothing owed.
- R11: When a refresh is owed and sleepReq is high in the same idle cycle, the refresh runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busGrant | input | 1 | Access controller hands the pins to this block |
| sleepReq | input | 1 | Request to enter self refresh |
| wakeReq | input | 1 | Request to leave self refresh |
| busReq | output | 1 | This block wants or holds the pins |
| ready | output | 1 | Initialization done, normal accesses allowed |
| rasN | output | 1 | Row strobe, active low |
| ucasN | output | 1 | Upper column strobe, active low |
| lcasN | output | 1 | Lower column strobe, active low |
| weN | output | 1 | Write enable, active low |

## Verification
The bench withholds the grant during wake-up. A design that waited for the grant there would never become ready. The grant is then withheld across ten refresh slots. A design without saturation would run more than MAX_OWED refreshes, or keep busReq high after eight. Sleep is requested while a refresh is owed, and wake is requested long before the minimum hold has passed. A design with the wrong priority would enter self refresh with a refresh still owed. One that honoured wake too early would give a short row-low time. One that skipped or doubled the exit CBR would give the wrong strobe spacing or a stray busReq.

// File: rtl/drefresh_pkg.sv
package drefresh_pkg;

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_CSET, ST_RLOW, ST_PRE, ST_SENT, ST_SHOLD, ST_SEXIT
  } seqState_t;

  typedef enum logic [2:0] {
    PH_CSR, PH_RAS, PH_RP, PH_SELF, PH_RPS
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      owedDec;
    logic      owedClr;
    logic      countEn;
  } seqCmd_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import drefresh_pkg::*;
#(
  parameter int PWRUP_CYC    = 40000000,
  parameter int REF_CYC      = 3120,
  parameter int T_CSR_CYC    = 2,
  parameter int T_RAS_CYC    = 10,
  parameter int T_RP_CYC     = 6,
  parameter int SELF_MIN_CYC = 20000,
  parameter int T_RPS_CYC    = 19,
  parameter int MAX_OWED     = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  seqCmd_t cmd,
  output logic    phaseDone,
  output logic    owedAny
);
  localparam int M1 = (PWRUP_CYC > SELF_MIN_CYC) ? PWRUP_CYC : SELF_MIN_CYC;
  localparam int M2 = (T_RAS_CYC > T_RPS_CYC) ? T_RAS_CYC : T_RPS_CYC;
  localparam int M3 = (T_CSR_CYC > T_RP_CYC) ? T_CSR_CYC : T_RP_CYC;
  localparam int M4 = (M2 > M3) ? M2 : M3;
  localparam int LONGEST = (M1 > M4) ? M1 : M4;
  localparam int CW = $clog2(LONGEST + 1);
  localparam int TW = $clog2(REF_CYC);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [CW-1:0] phaseCnt, phaseLen;
  logic [TW-1:0] tickCnt;
  logic [OW-1:0] owed;
  logic          tickNow, owedInc;

  always_comb begin
    case (cmd.phaseSel)
      PH_CSR:  phaseLen = CW'(T_CSR_CYC - 1);
      PH_RAS:  phaseLen = CW'(T_RAS_CYC - 1);
      PH_RP:   phaseLen = CW'(T_RP_CYC - 1);
      PH_SELF: phaseLen = CW'(SELF_MIN_CYC - 1);
      default: phaseLen = CW'(T_RPS_CYC - 1);
    endcase
  end

  // one counter times every phase, the power-up pause included
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= CW'(PWRUP_CYC - 1);
    else if (cmd.phaseLoad) phaseCnt <= phaseLen;
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end
  assign phaseDone = (phaseCnt == '0);

  assign tickNow = (tickCnt == TW'(REF_CYC - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (tickNow) tickCnt <= '0;
    else              tickCnt <= tickCnt + 1'b1;
  end

  assign owedInc = tickNow && cmd.countEn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else if (cmd.owedClr) owed <= '0;
    else if (owedInc && !cmd.owedDec && owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
    else if (!owedInc && cmd.owedDec && owed != '0) owed <= owed - 1'b1;
  end
  assign owedAny = (owed != '0);

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import drefresh_pkg::*;
#(
  parameter int INIT_CBR = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busGrant,
  input  logic    sleepReq,
  input  logic    wakeReq,
  input  logic    phaseDone,
  input  logic    owedAny,
  output seqCmd_t cmd,
  output logic    busReq,
  output logic    ready,
  output logic    rasN,
  output logic    ucasN,
  output logic    lcasN,
  output logic    weN
);
  localparam int IW = $clog2(INIT_CBR + 1);

  seqState_t state, nxtState;
  logic [IW-1:0] initLeft;
  logic postSelf, selfBusy, casLow, endCycle;

  assign ready    = (initLeft == '0);
  assign selfBusy = (state == ST_SENT) || (state == ST_SHOLD) || (state == ST_SEXIT);
  assign endCycle = (state == ST_PRE) && phaseDone;

  always_comb begin
    nxtState      = state;
    cmd.phaseLoad = 1'b0;
    cmd.phaseSel  = PH_CSR;
    cmd.owedDec   = 1'b0;
    cmd.owedClr   = 1'b0;
    cmd.countEn   = ready && !selfBusy;
    case (state)
      ST_PWR: if (phaseDone) nxtState = ST_IDLE;
      ST_IDLE: begin
        if (!ready || (busGrant && owedAny)) begin
          nxtState = ST_CSET; cmd.phaseLoad = 1'b1;
        end else if (busGrant && sleepReq) begin
          nxtState = ST_SENT; cmd.phaseLoad = 1'b1; cmd.owedClr = 1'b1;
        end
      end
      ST_CSET: if (phaseDone) begin
        nxtState = ST_RLOW; cmd.phaseLoad = 1'b1; cmd.phaseSel = PH_RAS;
      end
      ST_RLOW: if (phaseDone) begin
        nxtState = ST_PRE; cmd.phaseLoad = 1'b1; cmd.phaseSel = PH_RP;
      end
      ST_PRE: if (phaseDone) begin
        nxtState = ST_IDLE; cmd.owedDec = ready && !postSelf;
      end
      ST_SENT: if (phaseDone) begin
        nxtState = ST_SHOLD; cmd.phaseLoad = 1'b1; cmd.phaseSel = PH_SELF;
      end
      ST_SHOLD: if (phaseDone && wakeReq) begin
        nxtState = ST_SEXIT; cmd.phaseLoad = 1'b1; cmd.phaseSel = PH_RPS;
      end
      default: if (phaseDone) begin
        nxtState = ST_CSET; cmd.phaseLoad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWR;
      initLeft <= IW'(INIT_CBR);
      postSelf <= 1'b0;
    end else begin
      state <= nxtState;
      if (endCycle && initLeft != '0) initLeft <= initLeft - 1'b1;
      if (state == ST_SEXIT && phaseDone) postSelf <= 1'b1;
      else if (endCycle)                  postSelf <= 1'b0;
    end
  end

  assign casLow = (state == ST_CSET) || (state == ST_RLOW) ||
                  (state == ST_SENT) || (state == ST_SHOLD);
  assign rasN   = !((state == ST_RLOW) || (state == ST_SHOLD));
  assign ucasN  = !casLow;
  assign lcasN  = !casLow;
  assign weN    = 1'b1;
  assign busReq = (state != ST_PWR) &&
                  ((state != ST_IDLE) || !ready || owedAny || sleepReq);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drefresh_pkg::*;
#(
  parameter int PWRUP_CYC    = 40000000,
  parameter int REF_CYC      = 3120,
  parameter int INIT_CBR     = 8,
  parameter int T_CSR_CYC    = 2,
  parameter int T_RAS_CYC    = 10,
  parameter int T_RP_CYC     = 6,
  parameter int SELF_MIN_CYC = 20000,
  parameter int T_RPS_CYC    = 19,
  parameter int MAX_OWED     = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGrant,
  input  logic sleepReq,
  input  logic wakeReq,
  output logic busReq,
  output logic ready,
  output logic rasN,
  output logic ucasN,
  output logic lcasN,
  output logic weN
);
  seqCmd_t cmd;
  logic    phaseDone, owedAny;

  refresh_control #(.INIT_CBR(INIT_CBR)) ctrl_i (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .phaseDone(phaseDone), .owedAny(owedAny), .cmd(cmd),
    .busReq(busReq), .ready(ready), .rasN(rasN), .ucasN(ucasN),
    .lcasN(lcasN), .weN(weN)
  );

  refresh_datapath #(
    .PWRUP_CYC(PWRUP_CYC), .REF_CYC(REF_CYC), .T_CSR_CYC(T_CSR_CYC),
    .T_RAS_CYC(T_RAS_CYC), .T_RP_CYC(T_RP_CYC), .SELF_MIN_CYC(SELF_MIN_CYC),
    .T_RPS_CYC(T_RPS_CYC), .MAX_OWED(MAX_OWED)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .phaseDone(phaseDone), .owedAny(owedAny)
  );

endmodule

// File: rtl/refresh_seq_checker.sv
module refresh_seq_checker #(
  parameter int T_RAS_CYC = 10,
  parameter int T_RP_CYC  = 6
) (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic ready,
  input logic rasN,
  input logic ucasN,
  input logic lcasN
);
  logic [15:0] lowLen, highLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= 16'hFFFF;
    end else if (rasN) begin
      lowLen  <= '0;
      if (highLen != 16'hFFFF) highLen <= highLen + 1'b1;
    end else begin
      highLen <= '0;
      if (lowLen != 16'hFFFF) lowLen <= lowLen + 1'b1;
    end
  end

  a_r4_ras_with_cas: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (!ucasN && !lcasN));

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $past(!ucasN && !lcasN));

  a_r4_ras_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowLen >= 16'(T_RAS_CYC)));

  a_r4_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (highLen >= 16'(T_RP_CYC + 1)));

  a_r7_drive_owned: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !ucasN || !lcasN) |-> busReq);

  a_r3_ready_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

endmodule

bind dram_refresh_seq refresh_seq_checker #(
  .T_RAS_CYC(T_RAS_CYC), .T_RP_CYC(T_RP_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .busReq(busReq), .ready(ready),
  .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  localparam int PWR = 50, REF = 250, NINIT = 8, CSR = 2, RAS = 10,
                 RP = 6, SMIN = 40, RPS = 19, MAXO = 8;

  logic clk = 1'b0, rstN = 1'b0, busGrant = 1'b0, sleepReq = 1'b0, wakeReq = 1'b0;
  logic busReq, ready, rasN, ucasN, lcasN, weN;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWR), .REF_CYC(REF), .INIT_CBR(NINIT), .T_CSR_CYC(CSR),
    .T_RAS_CYC(RAS), .T_RP_CYC(RP), .SELF_MIN_CYC(SMIN), .T_RPS_CYC(RPS),
    .MAX_OWED(MAXO)
  ) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase names and remaining cycles
  typedef enum int {M_PAUSE, M_IDLE, M_SETUP, M_ROW, M_PRE, M_SIN, M_SELF, M_SOUT} mPhase_e;
  mPhase_e mPh = M_PAUSE;
  int mLeft = PWR - 1, mTick = 0, mOwed = 0, mInit = NINIT, edges = 0;
  bit mAfterSelf = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = M_PAUSE; mLeft = PWR - 1; mTick = 0; mOwed = 0; mInit = NINIT;
      mAfterSelf = 0; edges = 0;
    end else begin
      automatic bit rdy = (mInit == 0);
      automatic bit tk = (mTick == REF - 1);
      automatic bit inSelf = (mPh == M_SIN || mPh == M_SELF || mPh == M_SOUT);
      automatic int add = (tk && rdy && !inSelf) ? 1 : 0;
      automatic int take = 0;
      automatic bit wipe = 0;
      automatic int load = 0;
      automatic mPhase_e nPh = mPh;
      automatic bit over = (mLeft == 0);
      edges++;
      case (mPh)
        M_PAUSE: if (over) nPh = M_IDLE;
        M_IDLE:
          if (!rdy || (busGrant && mOwed > 0)) begin nPh = M_SETUP; load = CSR; end
          else if (busGrant && sleepReq) begin nPh = M_SIN; load = CSR; wipe = 1; end
        M_SETUP: if (over) begin nPh = M_ROW; load = RAS; end
        M_ROW:   if (over) begin nPh = M_PRE; load = RP; end
        M_PRE:   if (over) begin
                   nPh = M_IDLE;
                   if (mInit > 0) mInit--;
                   else if (!mAfterSelf) take = 1;
                   mAfterSelf = 0;
                 end
        M_SIN:   if (over) begin nPh = M_SELF; load = SMIN; end
        M_SELF:  if (over && wakeReq) begin nPh = M_SOUT; load = RPS; end
        M_SOUT:  if (over) begin nPh = M_SETUP; load = CSR; mAfterSelf = 1; end
      endcase
      if (wipe) mOwed = 0;
      else if (add == 1 && take == 0) mOwed = (mOwed < MAXO) ? mOwed + 1 : mOwed;
      else if (add == 0 && take == 1 && mOwed > 0) mOwed--;
      mTick = tk ? 0 : mTick + 1;
      if (load > 0) mLeft = load - 1;
      else if (mLeft > 0) mLeft--;
      mPh = nPh;
    end
  end

  // per-cycle comparison and strobe run tracking
  int falls = 0, runLen = 0, lastLow = 0, lastHigh = 0;
  logic prevRas = 1'b1;
  always @(negedge clk) begin
    automatic bit eRow = (mPh == M_ROW || mPh == M_SELF);
    automatic bit eCol = eRow || mPh == M_SETUP || mPh == M_SIN;
    automatic bit eReq = (mPh != M_PAUSE) &&
                         (mPh != M_IDLE || mInit != 0 || mOwed != 0 || sleepReq);
    check(rasN === !eRow, "R4 rasN", rasN, !eRow);
    check(ucasN === !eCol && lcasN === !eCol, "R4 casN", ucasN, !eCol);
    check(weN === 1'b1, "R5 weN", weN, 1);
    check(busReq === eReq, "R7 busReq", busReq, eReq);
    check(ready === (mInit == 0), "R3 ready", ready, mInit == 0);
    if (prevRas && !rasN) begin falls++; lastHigh = runLen; runLen = 1; end
    else if (!prevRas && rasN) begin lastLow = runLen; runLen = 1; end
    else runLen++;
    prevRas = rasN;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic toPhase(input int p);
    do cyc(1); while ((edges % REF) != p);
  endtask

  initial begin
    int f0;
    cyc(3);
    check(rasN && ucasN && lcasN && weN, "R1 strobes idle in reset", rasN, 1);
    check(!busReq && !ready, "R1 busReq/ready low in reset", busReq | ready, 0);
    rstN = 1'b1;
    cyc(PWR - 1);
    check(!busReq && rasN && ucasN, "R2 pause still quiet", busReq, 0);
    cyc(1);
    check(busReq, "R2 request after pause", busReq, 1);
    while (!ready) cyc(1);
    check(falls == NINIT, "R3 wake-up CBR count without grant", falls, NINIT);
    check(lastLow == RAS, "R4 row low width", lastLow, RAS);

    busGrant = 1'b1;
    cyc(2 * REF);
    check(lastLow == RAS, "R6 periodic refresh width", lastLow, RAS);

    // R6/R7: withhold grant across ten slots
    toPhase(50);
    busGrant = 1'b0;
    f0 = falls;
    cyc(10 * REF);
    check(falls == f0, "R7 no refresh without grant", falls - f0, 0);
    check(busReq, "R7 request held while owed", busReq, 1);
    busGrant = 1'b1;
    toPhase(230);
    check(falls - f0 == MAXO, "R6 owed count saturates", falls - f0, MAXO);
    check(!busReq, "R6 nothing owed after drain", busReq, 0);
    check(lastHigh == RP + 1 + CSR, "R8 back-to-back spacing", lastHigh, RP + 1 + CSR);

    // R11, R9, R10: refresh owed together with a sleep request
    busGrant = 1'b0;
    toPhase(50);
    sleepReq = 1'b1;
    busGrant = 1'b1;
    f0 = falls;
    while (falls == f0) cyc(1);
    while (!rasN) cyc(1);
    check(lastLow == RAS, "R11 owed refresh before sleep", lastLow, RAS);
    while (falls == f0 + 1) cyc(1);
    cyc(5);
    wakeReq = 1'b1;
    sleepReq = 1'b0;
    while (!rasN) cyc(1);
    check(lastLow == SMIN, "R9 self hold ignores early wake", lastLow, SMIN);
    wakeReq = 1'b0;
    while (rasN) cyc(1);
    check(lastHigh == RPS + CSR, "R10 exit precharge then CBR", lastHigh, RPS + CSR);
    while (!rasN) cyc(1);
    check(lastLow == RAS, "R10 exit CBR width", lastLow, RAS);
    cyc(30);
    check(falls - f0 == 3, "R10 exactly one CBR after exit", falls - f0, 3);
    check(!busReq, "R10 idle with nothing owed", busReq, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule